// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles a conditional branch while the branch is still in the decode stage of a five-stage pipeline. It does not wait for the execute stage. Each branch has one register operand. The branch condition is only whether that operand is zero or non-zero. A dedicated zero detector makes that test. A dedicated adder forms the taken target in the same cycle. With both available in decode, a taken branch costs one fetch slot instead of three.

When a branch is taken and the pipeline is not stalled, the block does two things. It selects the target as the next fetch address. It also flushes the single instruction already fetched behind the branch, which turns the IF/ID entry into a no-op. The block owns the fetch PC register. That register moves to the target, to the next sequential word, or holds, depending on the branch result and the external stall. Operand forwarding into decode and branch prediction are handled elsewhere.

Top module: `br_resolve_id`

## Requirements
- R1: For a branch of kind 2'b01 (branch-if-zero) with `id_valid` high, `take_o` is 1 exactly when all bits of `id_operand` are 0.
- R2: For a branch of kind 2'b10 (branch-if-nonzero) with `id_valid` high, `take_o` is 1 exactly when at least one bit of `id_operand` is 1.
- R3: Kind 2'b00 (not a branch), kind 2'b11 (reserved), or `id_valid` low each give `take_o` = 0.
- R4: `tgt_o` always equals `id_pc4 + (id_offset << 2)`, taken modulo 2^32, whether or not the branch is taken.
- R5: When `take_o` is 1 and `hz_stall` is 0, `pc_sel_o` and `flush_o` are both 1 in that cycle, and after the next clock edge `fetch_pc_o` equals that cycle's `tgt_o`.
- R6: When `pc_sel_o` is 0 and `hz_stall` is 0, `fetch_pc_o` advances by 4 on the next clock edge, with no flush.
- R7: While `hz_stall` is 1, `pc_sel_o` and `flush_o` are 0 and `fetch_pc_o` holds its value. `take_o` still reports the condition.
- R8: While `rst_n` is low, `fetch_pc_o` equals the parameter RESET_PC (default 32'h0000_0100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hz_stall | input | 1 | External hazard stall; blocks redirect and flush |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_kind | input | 2 | Branch kind: 00 none, 01 if-zero, 10 if-nonzero, 11 reserved |
| id_operand | input | 32 | Register operand under test |
| id_offset | input | 32 | Sign-extended word offset |
| id_pc4 | input | 32 | Address of the branch plus 4 |
| take_o | output | 1 | Branch condition met |
| tgt_o | output | 32 | Computed branch target |
| pc_sel_o | output | 1 | Next fetch address comes from the target |
| flush_o | output | 1 | Clear IF/ID to a no-op |
| fetch_pc_o | output | 32 | Fetch PC register |

## Verification
The assertions check the following relations on every cycle:
- Redirect and flush always move together, and both are blocked by a stall.
- A redirect lands the fetch PC on the previous cycle's target.
- A sequential cycle adds 4 to the fetch PC.
- A stall freezes the fetch PC.
- The zero and non-zero conditions agree with the operand, and no taken flag appears for an idle slot or a non-branch kind.

Only the bench scenarios can show that the target arithmetic wraps and sign-extends correctly. The same holds for operands with a single bit set at either end, and for back-to-back taken branches and taken branches held under stall, which give the right PC sequence.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_EQZ  = 2'b01,
    BK_NEZ  = 2'b10,
    BK_RSVD = 2'b11
  } br_kind_e;

  // target = pc+4 + offset*4, wrapping
  function automatic logic [31:0] br_target(input logic [31:0] pc4,
                                            input logic [31:0] off);
    return pc4 + {off[29:0], 2'b00};
  endfunction

  function automatic logic br_cond(input br_kind_e k, input logic is_zero);
    case (k)
      BK_EQZ:  return is_zero;
      BK_NEZ:  return ~is_zero;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/br_zero_detect.sv
module br_zero_detect #(
  parameter int W     = 32,
  parameter int CHUNK = 8
) (
  input  logic [W-1:0] op,
  output logic         is_zero
);
  localparam int NCH = (W + CHUNK - 1) / CHUNK;

  logic [NCH-1:0] chunk_any;

  // chunked OR, then a final NOR across the chunks
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chunk
      always_comb begin
        chunk_any[c] = 1'b0;
        for (int b = 0; b < CHUNK; b++) begin
          if (c * CHUNK + b < W) chunk_any[c] = chunk_any[c] | op[c * CHUNK + b];
        end
      end
    end
  endgenerate

  assign is_zero = ~|chunk_any;
endmodule

// File: rtl/br_target_add.sv
module br_target_add (
  input  logic [31:0] pc4,
  input  logic [31:0] off,
  output logic [31:0] tgt
);
  import br_pkg::*;
  assign tgt = br_target(pc4, off);
endmodule

// File: rtl/br_decide.sv
module br_decide (
  input  logic       valid,
  input  logic [1:0] kind,
  input  logic       is_zero,
  input  logic       stall,
  output logic       take,
  output logic       redirect
);
  import br_pkg::*;
  br_kind_e k;
  assign k        = br_kind_e'(kind);
  assign take     = valid & br_cond(k, is_zero);
  assign redirect = take & ~stall;
endmodule

// File: rtl/br_resolve_id.sv
module br_resolve_id #(
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter int          CHUNK    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hz_stall,
  input  logic        id_valid,
  input  logic [1:0]  id_kind,
  input  logic [31:0] id_operand,
  input  logic [31:0] id_offset,
  input  logic [31:0] id_pc4,
  output logic        take_o,
  output logic [31:0] tgt_o,
  output logic        pc_sel_o,
  output logic        flush_o,
  output logic [31:0] fetch_pc_o
);
  localparam int W = 32;

  logic        zero_w;
  logic        redirect_w;
  logic [W-1:0] pc_q;
  logic [W-1:0] pc_seq_w;

  br_zero_detect #(.W(W), .CHUNK(CHUNK)) u_zero (
    .op      (id_operand),
    .is_zero (zero_w)
  );

  br_target_add u_tadd (
    .pc4 (id_pc4),
    .off (id_offset),
    .tgt (tgt_o)
  );

  br_decide u_dec (
    .valid    (id_valid),
    .kind     (id_kind),
    .is_zero  (zero_w),
    .stall    (hz_stall),
    .take     (take_o),
    .redirect (redirect_w)
  );

  assign pc_seq_w = pc_q + 32'd4;

  always_ff @(posedge clk) begin
    if (!rst_n)          pc_q <= RESET_PC;
    else if (hz_stall)   pc_q <= pc_q;
    else if (redirect_w) pc_q <= tgt_o;
    else                 pc_q <= pc_seq_w;
  end

  assign pc_sel_o   = redirect_w;
  assign flush_o    = redirect_w;
  assign fetch_pc_o = pc_q;
endmodule

// File: rtl/br_resolve_checks.sv
module br_resolve_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        hz_stall,
  input logic        id_valid,
  input logic [1:0]  id_kind,
  input logic [31:0] id_operand,
  input logic        take_o,
  input logic [31:0] tgt_o,
  input logic        pc_sel_o,
  input logic        flush_o,
  input logic [31:0] fetch_pc_o
);
  a_r1_eqz_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_kind == 2'b01) |-> (take_o == (id_operand == 32'd0)));

  a_r2_nez_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_kind == 2'b10) |-> (take_o == (id_operand != 32'd0)));

  a_r3_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid || id_kind == 2'b00 || id_kind == 2'b11) |-> !take_o);

  a_r5_flush_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !hz_stall) |-> (pc_sel_o && flush_o));

  a_r5_pc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_o |=> (fetch_pc_o == $past(tgt_o)));

  a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_sel_o && !hz_stall) |=> (fetch_pc_o == $past(fetch_pc_o) + 32'd4));

  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hz_stall |-> (!pc_sel_o && !flush_o));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    hz_stall |=> $stable(fetch_pc_o));
endmodule

bind br_resolve_id br_resolve_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hz_stall   (hz_stall),
  .id_valid   (id_valid),
  .id_kind    (id_kind),
  .id_operand (id_operand),
  .take_o     (take_o),
  .tgt_o      (tgt_o),
  .pc_sel_o   (pc_sel_o),
  .flush_o    (flush_o),
  .fetch_pc_o (fetch_pc_o)
);

// File: tb/br_resolve_id_test.sv
module br_resolve_id_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC     = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hz_stall = 1'b0;
  logic        id_valid = 1'b0;
  logic [1:0]  id_kind = 2'b00;
  logic [31:0] id_operand = '0;
  logic [31:0] id_offset = '0;
  logic [31:0] id_pc4 = '0;
  logic        take_o, pc_sel_o, flush_o;
  logic [31:0] tgt_o, fetch_pc_o;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic        take;
    logic [31:0] tgt;
    logic        sel;
    logic [31:0] pc;
    string       tag;
    string       pctag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model_pc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  br_resolve_id #(.RESET_PC(RST_PC)) uut (
    .clk(clk), .rst_n(rst_n), .hz_stall(hz_stall), .id_valid(id_valid),
    .id_kind(id_kind), .id_operand(id_operand), .id_offset(id_offset),
    .id_pc4(id_pc4), .take_o(take_o), .tgt_o(tgt_o), .pc_sel_o(pc_sel_o),
    .flush_o(flush_o), .fetch_pc_o(fetch_pc_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // driver: apply one decode-stage cycle and push its expectation
  task automatic drive(logic v, logic [1:0] k, logic [31:0] op, logic [31:0] off,
                       logic [31:0] pc4, logic st, string tag);
    exp_t e;
    logic cond;
    @(negedge clk);
    id_valid = v; id_kind = k; id_operand = op; id_offset = off;
    id_pc4 = pc4; hz_stall = st;
    if (k == 2'b01)      cond = (op == 0);
    else if (k == 2'b10) cond = (op != 0);
    else                 cond = 1'b0;
    e.take = v && cond;
    e.tgt  = pc4 + off * 32'd4;
    e.sel  = e.take && !st;
    e.tag  = tag;
    if (st) begin
      e.pc = model_pc;        e.pctag = "R7";
    end else if (e.sel) begin
      e.pc = e.tgt;           e.pctag = "R5";
    end else begin
      e.pc = model_pc + 32'd4; e.pctag = "R6";
    end
    model_pc = e.pc;
    sb.push_back(e);
  endtask

  // monitor: just after each edge, compare combinational outputs and new PC
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "take_o", {31'd0, take_o}, {31'd0, e.take});
        check("R4", "tgt_o", tgt_o, e.tgt);
        check(e.sel ? "R5" : "R7", "pc_sel_o", {31'd0, pc_sel_o}, {31'd0, e.sel});
        check(e.sel ? "R5" : "R7", "flush_o", {31'd0, flush_o}, {31'd0, e.sel});
        check(e.pctag, "fetch_pc_o", fetch_pc_o, e.pc);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    model_pc = RST_PC;
    repeat (3) @(posedge clk);
    #1;
    check("R8", "fetch_pc_o in reset", fetch_pc_o, RST_PC);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: branch-if-zero, both outcomes
    drive(1, 2'b01, 32'd0,          32'd4,          32'h0000_1004, 0, "R1");
    drive(1, 2'b01, 32'h0000_0001,  32'd4,          32'h0000_2004, 0, "R1");
    drive(1, 2'b01, 32'h8000_0000,  32'd8,          32'h0000_2008, 0, "R1");
    // R2: branch-if-nonzero
    drive(1, 2'b10, 32'h8000_0000,  32'hFFFF_FFFE,  32'h0000_3000, 0, "R2");
    drive(1, 2'b10, 32'd0,          32'd16,         32'h0000_3004, 0, "R2");
    drive(1, 2'b10, 32'h0000_0001,  32'd1,          32'h0000_4000, 0, "R2");
    // R3: not a branch, reserved, invalid slot
    drive(1, 2'b00, 32'd0,          32'd5,          32'h0000_5000, 0, "R3");
    drive(1, 2'b11, 32'd0,          32'd5,          32'h0000_5004, 0, "R3");
    drive(0, 2'b01, 32'd0,          32'd5,          32'h0000_5008, 0, "R3");
    // R4: wrap-around target, negative offset
    drive(1, 2'b01, 32'd0,          32'h0000_0001,  32'hFFFF_FFFC, 0, "R4");
    drive(1, 2'b10, 32'h1234_5678,  32'h8000_0000,  32'h0000_0010, 0, "R4");
    // R7: stall holds a taken branch; then released
    drive(1, 2'b01, 32'd0,          32'd32,         32'h0000_6004, 1, "R7");
    drive(1, 2'b01, 32'd0,          32'd32,         32'h0000_6004, 1, "R7");
    drive(1, 2'b01, 32'd0,          32'd32,         32'h0000_6004, 0, "R5");
    drive(0, 2'b00, 32'd0,          32'd0,          32'h0000_0000, 1, "R7");
    // R5: back-to-back taken branches
    drive(1, 2'b10, 32'd3,          32'd2,          32'h0000_7004, 0, "R5");
    drive(1, 2'b10, 32'd3,          32'hFFFF_FFF0,  32'h0000_8004, 0, "R5");
    // R6: sequential run
    drive(0, 2'b00, 32'd0,          32'd0,          32'd0,         0, "R6");
    drive(0, 2'b00, 32'd0,          32'd0,          32'd0,         0, "R6");
    // mixed pseudo-random traffic
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] op;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = lfsr[3] ? 32'd0 : (lfsr << lfsr[8:4]);
      drive(lfsr[0] | lfsr[9], lfsr[2:1], op, {{20{lfsr[15]}}, lfsr[15:4]},
            {lfsr[31:2], 2'b00}, lfsr[7] & lfsr[11],
            lfsr[2:1] == 2'b01 ? "R1" : (lfsr[2:1] == 2'b10 ? "R2" : "R3"));
    end
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule